// File: doc/BRIEF.md
# Store-Multiple Write Burst Splitter

This block turns one store-multiple request into one or two incrementing write-address commands, each with its own write-data beats and byte strobes, on a 64-bit write-data channel. A request carries a word-aligned start address, a count of 32-bit registers and the register data packed into one vector. The block takes the request in a single handshake when it is idle. It then works out, for each command, whether the beats are 64 or 32 bits wide and how many there are.

Requests that would run past the last word of their 32-byte line are split in two. The first command covers the start word up to word 7 of the line. The second command goes back to offset 0x00 of the same line and carries the remaining registers, so the line wraps around rather than continuing into the next line. The second address command is only issued after the first has been accepted. All data beats of a command follow its address handshake, and all first-command beats come before any second-command beat.

Top module: `stm_burst_splitter`

## Requirements
- R1: After reset `req_ready_o` is 1 and both `aw_valid_o` and `w_valid_o` are 0. A request is taken when `req_valid_i` and `req_ready_o` are both 1. `req_ready_o` stays 0 from the cycle after acceptance until the final address and data handshakes of that request have completed, and then returns to 1.
- R2: Every command has `aw_burst_o` = 2'b01 (incrementing). Its address is the line of the request, with bits [4:2] set to that command's first word index in the line and bits [1:0] set to 0.
- R3: A command uses 64-bit beats (`aw_size_o` = 3) only when its first word index is even and its word count is even. Every other command uses 32-bit beats (`aw_size_o` = 2).
- R4: `aw_len_o` equals the command's beat count minus one. The beat count is half the word count for 64-bit beats and equal to the word count for 32-bit beats.
- R5: If start word index plus count exceeds 8, two commands are issued. The first has 8 minus the start index words, at the start address. The second has the remaining words at line offset 0x00. Otherwise exactly one command is issued.
- R6: The second address command is not valid before the first address handshake has completed. No data beat of a command is valid before that command's address handshake has completed. All first-command beats come before any second-command beat.
- R7: On a 32-bit beat to an odd word index, the strobe is 0xF0, the word is on bits [63:32] and bits [31:0] are 0. On an even word index, the strobe is 0x0F, the word is on bits [31:0] and bits [63:32] are 0.
- R8: On a 64-bit beat, the strobe is 0xFF. The earlier register is on bits [31:0] and the next register is on bits [63:32].
- R9: Register i, held in bits [32i+31:32i] of `req_data_i`, is written to the i-th word of the sequence that runs from the start word through word 7 and then continues from word 0.
- R10: `w_last_o` is 1 on the final beat of each command and 0 on every other beat.
- R11: While `aw_valid_o` is 1 and `aw_ready_i` is 0, the address command holds its valid and its fields in the next cycle. The same holds for `w_valid_o` with `w_ready_i` and the data, strobe and last outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle, request can be taken |
| req_addr_i | input | ADDR_W | Byte start address; bits [1:0] ignored |
| req_count_i | input | 4 | Number of registers, 1 to MAX_WORDS |
| req_data_i | input | 32*MAX_WORDS | Register data, register i in bits [32i+31:32i] |
| aw_addr_o | output | ADDR_W | Command start address |
| aw_burst_o | output | 2 | Burst type, always incrementing |
| aw_size_o | output | 3 | Beat size: 2 = 32-bit, 3 = 64-bit |
| aw_len_o | output | 8 | Beats minus one |
| aw_valid_o | output | 1 | Address command valid |
| aw_ready_i | input | 1 | Address command accepted |
| w_data_o | output | 64 | Write data |
| w_strb_o | output | 8 | Byte strobes |
| w_last_o | output | 1 | Final beat of the command |
| w_valid_o | output | 1 | Data beat valid |
| w_ready_i | input | 1 | Data beat accepted |

## Verification
A wrong command index in the address path would show a second-line offset or a wrong size in the very next address handshake. A stale piece selector or word offset in the data path would show on the next data beat as a strobe in the wrong half, a register out of order, or a missing or extra last flag. A busy flag stuck high or low shows on `req_ready_o` in the cycle after the final handshake. The sweep covers every start word with every count from 1 to 8, once with the receivers always ready and once with pseudo-random back-pressure. With back-pressure, a lost hold or an early second command is caught in the stalled cycle itself.

// File: rtl/stm_pkg.sv
package stm_pkg;
  localparam int LINE_WORDS = 8;
  localparam int WIDX_W     = $clog2(LINE_WORDS);
  localparam int CNT_W      = WIDX_W + 1;
  localparam int LINE_LSB   = WIDX_W + 2;

  localparam logic [1:0] BURST_INCR = 2'b01;
  localparam logic [2:0] SIZE_W32   = 3'd2;
  localparam logic [2:0] SIZE_W64   = 3'd3;

  typedef struct packed {
    logic [WIDX_W-1:0] word;
    logic [CNT_W-1:0]  nwords;
    logic              wide;
  } piece_t;
endpackage

// File: rtl/stm_split_plan.sv
module stm_split_plan
  import stm_pkg::*;
(
  input  logic [WIDX_W-1:0] word_i,
  input  logic [CNT_W-1:0]  count_i,
  output piece_t            p0_o,
  output piece_t            p1_o,
  output logic              split_o
);
  logic [CNT_W-1:0] room;

  always_comb begin
    room         = CNT_W'(LINE_WORDS) - CNT_W'(word_i);
    split_o      = count_i > room;
    p0_o.word    = word_i;
    p0_o.nwords  = split_o ? room : count_i;
    p1_o.word    = '0;
    p1_o.nwords  = split_o ? count_i - room : '0;
    // wide beats need an even start word and an even word count
    p0_o.wide    = ~word_i[0] & ~p0_o.nwords[0];
    p1_o.wide    = split_o & ~p1_o.nwords[0];
  end
endmodule

// File: rtl/stm_aw_issue.sv
module stm_aw_issue
  import stm_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     load_i,
  input  logic [ADDR_W-LINE_LSB-1:0] line_i,
  input  piece_t                   p0_i,
  input  piece_t                   p1_i,
  input  logic                     split_i,
  output logic [ADDR_W-1:0]        aw_addr_o,
  output logic [2:0]               aw_size_o,
  output logic [7:0]               aw_len_o,
  output logic                     aw_valid_o,
  input  logic                     aw_ready_i,
  output logic [1:0]               sent_o,
  output logic                     busy_o
);
  logic             active_q;
  logic [1:0]       sent_q;
  piece_t           cur;
  logic [CNT_W-1:0] beats;

  assign cur        = sent_q[0] ? p1_i : p0_i;
  assign beats      = cur.wide ? (cur.nwords >> 1) : cur.nwords;
  assign aw_addr_o  = {line_i, cur.word, 2'b00};
  assign aw_size_o  = cur.wide ? SIZE_W64 : SIZE_W32;
  assign aw_len_o   = 8'(beats) - 8'd1;
  assign aw_valid_o = active_q;
  assign busy_o     = active_q;
  assign sent_o     = sent_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      sent_q   <= 2'd0;
    end else if (load_i) begin
      active_q <= 1'b1;
      sent_q   <= 2'd0;
    end else if (active_q && aw_ready_i) begin
      sent_q <= sent_q + 2'd1;
      if (!(sent_q == 2'd0 && split_i)) active_q <= 1'b0;
    end
  end

  AST_AW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aw_valid_o && !aw_ready_i |=> aw_valid_o && $stable(aw_addr_o) && $stable(aw_size_o) && $stable(aw_len_o)); // R11
  AST_SPLIT_BASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aw_valid_o && sent_q == 2'd1 |-> aw_addr_o[LINE_LSB-1:0] == '0); // R5
  AST_WIDE_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aw_valid_o && aw_size_o == SIZE_W64 |-> !aw_addr_o[2]); // R3
endmodule

// File: rtl/stm_w_beats.sv
module stm_w_beats
  import stm_pkg::*;
#(
  parameter int MAX_WORDS = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   load_i,
  input  piece_t                 p0_i,
  input  piece_t                 p1_i,
  input  logic                   split_i,
  input  logic [32*MAX_WORDS-1:0] data_i,
  input  logic [1:0]             aw_sent_i,
  output logic [63:0]            w_data_o,
  output logic [7:0]             w_strb_o,
  output logic                   w_last_o,
  output logic                   w_valid_o,
  input  logic                   w_ready_i,
  output logic                   busy_o
);
  localparam int RIDX_W = $clog2(MAX_WORDS);
  localparam int ARR    = 1 << RIDX_W;

  logic [31:0]       wd [ARR];
  logic              active_q, piece_q;
  logic [CNT_W-1:0]  off_q;
  logic [RIDX_W-1:0] ridx_q;
  piece_t            cur;
  logic [CNT_W-1:0]  step;
  logic [WIDX_W-1:0] word_now;
  logic [31:0]       lo, hi;
  logic              hs;

  for (genvar i = 0; i < ARR; i++) begin : g_word
    if (i < MAX_WORDS) begin : g_used
      assign wd[i] = data_i[i*32 +: 32];
    end else begin : g_pad
      assign wd[i] = '0;
    end
  end

  assign cur       = piece_q ? p1_i : p0_i;
  assign step      = cur.wide ? CNT_W'(2) : CNT_W'(1);
  assign word_now  = cur.word + off_q[WIDX_W-1:0];
  assign lo        = wd[ridx_q];
  assign hi        = wd[ridx_q + RIDX_W'(1)];
  assign w_last_o  = (off_q + step) == cur.nwords;
  // a piece's beats wait for its own address handshake
  assign w_valid_o = active_q && (aw_sent_i > {1'b0, piece_q});
  assign hs        = w_valid_o && w_ready_i;
  assign busy_o    = active_q;

  always_comb begin
    if (cur.wide) begin
      w_data_o = {hi, lo};
      w_strb_o = 8'hFF;
    end else if (word_now[0]) begin
      w_data_o = {lo, 32'h0};
      w_strb_o = 8'hF0;
    end else begin
      w_data_o = {32'h0, lo};
      w_strb_o = 8'h0F;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      piece_q  <= 1'b0;
      off_q    <= '0;
      ridx_q   <= '0;
    end else if (load_i) begin
      active_q <= 1'b1;
      piece_q  <= 1'b0;
      off_q    <= '0;
      ridx_q   <= '0;
    end else if (hs) begin
      ridx_q <= ridx_q + RIDX_W'(step);
      if (w_last_o) begin
        off_q <= '0;
        if (!piece_q && split_i) piece_q <= 1'b1;
        else active_q <= 1'b0;
      end else begin
        off_q <= off_q + step;
      end
    end
  end

  AST_W_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_valid_o && !w_ready_i |=> w_valid_o && $stable(w_data_o) && $stable(w_strb_o) && $stable(w_last_o)); // R11
  AST_LOW_HALF_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_valid_o && w_strb_o == 8'h0F |-> w_data_o[63:32] == 32'h0); // R7
  AST_HIGH_HALF_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_valid_o && w_strb_o == 8'hF0 |-> w_data_o[31:0] == 32'h0); // R7
endmodule

// File: rtl/stm_burst_splitter.sv
module stm_burst_splitter
  import stm_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MAX_WORDS = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_valid_i,
  output logic                    req_ready_o,
  input  logic [ADDR_W-1:0]       req_addr_i,
  input  logic [CNT_W-1:0]        req_count_i,
  input  logic [32*MAX_WORDS-1:0] req_data_i,
  output logic [ADDR_W-1:0]       aw_addr_o,
  output logic [1:0]              aw_burst_o,
  output logic [2:0]              aw_size_o,
  output logic [7:0]              aw_len_o,
  output logic                    aw_valid_o,
  input  logic                    aw_ready_i,
  output logic [63:0]             w_data_o,
  output logic [7:0]              w_strb_o,
  output logic                    w_last_o,
  output logic                    w_valid_o,
  input  logic                    w_ready_i
);
  piece_t                    plan_p0, plan_p1, p0_q, p1_q;
  logic                      plan_split, split_q;
  logic [ADDR_W-LINE_LSB-1:0] line_q;
  logic [32*MAX_WORDS-1:0]   data_q;
  logic                      accept, aw_busy, w_busy;
  logic [1:0]                aw_sent;
  logic                      addr_unused;

  assign addr_unused = ^req_addr_i[1:0];
  assign req_ready_o = !aw_busy && !w_busy;
  assign accept      = req_valid_i && req_ready_o;
  assign aw_burst_o  = BURST_INCR;

  stm_split_plan u_plan (
    .word_i  (req_addr_i[LINE_LSB-1:2]),
    .count_i (req_count_i),
    .p0_o    (plan_p0),
    .p1_o    (plan_p1),
    .split_o (plan_split)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p0_q    <= '0;
      p1_q    <= '0;
      split_q <= 1'b0;
      line_q  <= '0;
      data_q  <= '0;
    end else if (accept) begin
      p0_q    <= plan_p0;
      p1_q    <= plan_p1;
      split_q <= plan_split;
      line_q  <= req_addr_i[ADDR_W-1:LINE_LSB];
      data_q  <= req_data_i;
    end
  end

  stm_aw_issue #(.ADDR_W(ADDR_W)) u_aw (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .line_i     (line_q),
    .p0_i       (p0_q),
    .p1_i       (p1_q),
    .split_i    (split_q),
    .aw_addr_o  (aw_addr_o),
    .aw_size_o  (aw_size_o),
    .aw_len_o   (aw_len_o),
    .aw_valid_o (aw_valid_o),
    .aw_ready_i (aw_ready_i),
    .sent_o     (aw_sent),
    .busy_o     (aw_busy)
  );

  stm_w_beats #(.MAX_WORDS(MAX_WORDS)) u_w (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (accept),
    .p0_i      (p0_q),
    .p1_i      (p1_q),
    .split_i   (split_q),
    .data_i    (data_q),
    .aw_sent_i (aw_sent),
    .w_data_o  (w_data_o),
    .w_strb_o  (w_strb_o),
    .w_last_o  (w_last_o),
    .w_valid_o (w_valid_o),
    .w_ready_i (w_ready_i),
    .busy_o    (w_busy)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !aw_valid_o && !w_valid_o); // R1
  AST_NO_DATA_AHEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_valid_o |-> aw_sent != 2'd0); // R6
endmodule

// File: tb/stm_burst_splitter_tb_top.sv
`timescale 1ns/1ps
module stm_burst_splitter_tb_top;
  localparam int ADDR_W    = 32;
  localparam int MAX_WORDS = 8;

  logic                    clk = 1'b0;
  logic                    rst_ni;
  logic                    req_valid_i;
  logic                    req_ready_o;
  logic [ADDR_W-1:0]       req_addr_i;
  logic [3:0]              req_count_i;
  logic [32*MAX_WORDS-1:0] req_data_i;
  logic [ADDR_W-1:0]       aw_addr_o;
  logic [1:0]              aw_burst_o;
  logic [2:0]              aw_size_o;
  logic [7:0]              aw_len_o;
  logic                    aw_valid_o, aw_ready_i;
  logic [63:0]             w_data_o;
  logic [7:0]              w_strb_o;
  logic                    w_last_o, w_valid_o, w_ready_i;

  int          n_checks = 0;
  int          n_fail   = 0;
  int          cyc      = 0;
  logic [15:0] lfsr     = 16'hACE1;

  always #2 clk = ~clk;

  stm_burst_splitter #(.ADDR_W(ADDR_W), .MAX_WORDS(MAX_WORDS)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_addr_i(req_addr_i), .req_count_i(req_count_i), .req_data_i(req_data_i),
    .aw_addr_o(aw_addr_o), .aw_burst_o(aw_burst_o), .aw_size_o(aw_size_o),
    .aw_len_o(aw_len_o), .aw_valid_o(aw_valid_o), .aw_ready_i(aw_ready_i),
    .w_data_o(w_data_o), .w_strb_o(w_strb_o), .w_last_o(w_last_o),
    .w_valid_o(w_valid_o), .w_ready_i(w_ready_i)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail   = n_fail + 1;
      n_checks = n_checks + 1;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] dword(input int id, input int i);
    return {16'hC0DE, 8'(id), 8'(i)};
  endfunction

  task automatic run_req(input int id, input int w, input int n, input bit stall);
    int ps[2], pn[2];
    logic [ADDR_W-1:0] ea[2];
    logic [2:0] es_sz[2];
    logic [7:0] el_len[2];
    logic [63:0] ed[16];
    logic [7:0]  es[16];
    bit          el[16];
    int          ep[16];
    int np, nb, r, aw_i, b_i, guard;
    bit aw_stall, w_stall;
    logic [ADDR_W-1:0] p_addr;
    logic [2:0] p_size;
    logic [7:0] p_len;
    logic [63:0] p_data;
    logic [7:0] p_strb;
    bit p_last;
    logic [26:0] tag;
    tag   = 27'(id * 37 + 5);
    ps[0] = w;
    pn[0] = (w + n > 8) ? 8 - w : n;
    ps[1] = 0;
    pn[1] = n - pn[0];
    np    = (pn[1] > 0) ? 2 : 1;
    nb = 0;
    r  = 0;
    for (int p = 0; p < np; p++) begin
      bit wide;
      int stp;
      wide = (ps[p] % 2 == 0) && (pn[p] % 2 == 0);
      stp  = wide ? 2 : 1;
      ea[p]     = {tag, 3'(ps[p]), 2'b00};
      es_sz[p]  = wide ? 3'd3 : 3'd2;
      el_len[p] = 8'((wide ? pn[p] / 2 : pn[p]) - 1);
      for (int k = 0; k < pn[p]; k += stp) begin
        int wn;
        wn = ps[p] + k;
        if (wide) begin
          ed[nb] = {dword(id, r + 1), dword(id, r)};
          es[nb] = 8'hFF;
        end else if (wn % 2 == 1) begin
          ed[nb] = {dword(id, r), 32'h0};
          es[nb] = 8'hF0;
        end else begin
          ed[nb] = {32'h0, dword(id, r)};
          es[nb] = 8'h0F;
        end
        el[nb] = (k + stp == pn[p]);
        ep[nb] = p;
        r += stp;
        nb++;
      end
    end

    @(negedge clk);
    req_valid_i = 1'b1;
    req_addr_i  = {tag, 3'(w), 2'(id)};
    req_count_i = 4'(n);
    for (int i = 0; i < MAX_WORDS; i++) req_data_i[i*32 +: 32] = dword(id, i);
    #1;
    check(req_ready_o == 1'b1, "R1 ready when idle", 64'(req_ready_o), 64'd1);

    aw_i = 0; b_i = 0; guard = 0;
    aw_stall = 1'b0; w_stall = 1'b0;
    while ((aw_i < np || b_i < nb) && guard < 200) begin
      @(negedge clk);
      req_valid_i = 1'b0;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      aw_ready_i = stall ? lfsr[0] : 1'b1;
      w_ready_i  = stall ? lfsr[3] : 1'b1;
      #1;
      if (guard == 0)
        check(req_ready_o == 1'b0, "R1 busy after accept", 64'(req_ready_o), 64'd0);
      if (aw_stall)
        check(aw_valid_o && aw_addr_o == p_addr && aw_size_o == p_size && aw_len_o == p_len,
              "R11 aw hold", 64'(aw_addr_o), 64'(p_addr));
      if (w_stall)
        check(w_valid_o && w_data_o == p_data && w_strb_o == p_strb && w_last_o == p_last,
              "R11 w hold", w_data_o, p_data);
      if (w_valid_o) begin
        check(b_i < nb, "R10 extra beat", 64'(b_i), 64'(nb));
        if (b_i < nb)
          check(ep[b_i] < aw_i, "R6 data before its address", 64'(aw_i), 64'(ep[b_i] + 1));
      end
      if (aw_valid_o)
        check(aw_i < np, "R5 extra command", 64'(aw_i), 64'(np));
      if (aw_valid_o && aw_ready_i && aw_i < np) begin
        check(aw_addr_o == ea[aw_i], "R2 R5 command address", 64'(aw_addr_o), 64'(ea[aw_i]));
        check(aw_burst_o == 2'b01, "R2 burst incr", 64'(aw_burst_o), 64'd1);
        check(aw_size_o == es_sz[aw_i], "R3 beat size", 64'(aw_size_o), 64'(es_sz[aw_i]));
        check(aw_len_o == el_len[aw_i], "R4 length", 64'(aw_len_o), 64'(el_len[aw_i]));
        aw_i++;
      end
      if (w_valid_o && w_ready_i && b_i < nb) begin
        check(w_strb_o == es[b_i], "R7 R8 strobe", 64'(w_strb_o), 64'(es[b_i]));
        check(w_data_o == ed[b_i], "R9 data placement", w_data_o, ed[b_i]);
        check(w_last_o == el[b_i], "R10 last flag", 64'(w_last_o), 64'(el[b_i]));
        b_i++;
      end
      aw_stall = aw_valid_o && !aw_ready_i;
      w_stall  = w_valid_o && !w_ready_i;
      p_addr = aw_addr_o; p_size = aw_size_o; p_len = aw_len_o;
      p_data = w_data_o;  p_strb = w_strb_o;  p_last = w_last_o;
      guard++;
    end
    check(guard < 200, "R1 request completes", 64'(guard), 64'd200);

    @(negedge clk);
    aw_ready_i = 1'b0;
    w_ready_i  = 1'b0;
    #1;
    check(req_ready_o && !aw_valid_o && !w_valid_o, "R1 idle after final handshake",
          {61'd0, req_ready_o, aw_valid_o, w_valid_o}, 64'd4);
  endtask

  initial begin
    int id;
    rst_ni      = 1'b0;
    req_valid_i = 1'b0;
    req_addr_i  = '0;
    req_count_i = '0;
    req_data_i  = '0;
    aw_ready_i  = 1'b0;
    w_ready_i   = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    check(req_ready_o == 1'b1, "R1 reset ready", 64'(req_ready_o), 64'd1);
    check(aw_valid_o == 1'b0, "R1 reset aw idle", 64'(aw_valid_o), 64'd0);
    check(w_valid_o == 1'b0, "R1 reset w idle", 64'(w_valid_o), 64'd0);
    id = 0;
    for (int pass = 0; pass < 2; pass++)
      for (int w = 0; w < 8; w++)
        for (int n = 1; n <= MAX_WORDS; n++) begin
          run_req(id, w, n, pass == 1);
          id++;
        end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule